// File: doc/BRIEF.md
# Legacy keyboard controller emulation registers

This block is the register file that lets a USB host path pose as an old PC keyboard controller. It holds a control word, a one-byte input buffer, a one-byte output buffer and a one-byte status word. Firmware reaches all four through a 32-bit native memory-mapped window. While emulation is switched on, legacy software reaches them through the 8-bit data port (060h) and the command/status port (064h). A separate 8-bit Port A register at 092h is always present.

Legacy accesses have side effects on three status flags. The flags are output full (bit 0), input full (bit 1) and command/data (bit 3). Emulation firmware places keyboard and mouse bytes in the output buffer and collects the bytes that legacy software writes. A one-cycle notify pulse tells the firmware that a byte has arrived or that its staged byte has been taken. Native reads are combinational on the address. Legacy reads are combinational on the port address.

Top module: `kbd_emu_regs`

## Requirements
- R1: Reset values are:
  - control 00000010h
  - input buffer, output buffer and status 0
  - Port A 00h
  - notify 0
- R2: Native offsets map the registers as follows:
  - 100h is control, 32 bits
  - 104h is the input buffer
  - 108h is the output buffer
  - 10Ch is status

  Each of the three 8-bit registers keeps wdata[7:0] and reads back zero in bits [31:8].
- R3: A native write to any other offset changes no register, and a native read from any other offset returns 0. This includes misaligned offsets and offsets outside 100h–10Ch.
- R4: With emulation enabled, a legacy read of port 060h returns the output buffer in io_rdata. It also clears status bit 0 (output full).
- R5: With emulation enabled, a legacy write to 060h loads io_wdata into the input buffer, sets status bit 1 (input full) and clears status bit 3 (command/data).
- R6: With emulation enabled, a legacy read of 064h returns the status byte and changes no register.
- R7: With emulation enabled, a legacy write to 064h loads io_wdata into the input buffer, clears status bit 1 and sets status bit 3.
- R8: Emulation is enabled when control bit 0 is 1. When control bit 0 is 0, ports 060h and 064h are not decoded: io_hit is 0, io_rdata is 0 and no register changes.
- R9: Port A at 092h is an 8-bit read/write register that is decoded whatever the state of control bit 0. io_hit is 1 for every decoded legacy access.
- R10: notify is high for exactly one cycle, the cycle in which status first shows either input full rising from 0 to 1 or output full falling from 1 to 0.
- R11: When a native write and a legacy access occur in the same cycle, the legacy side effect wins for the input buffer and for the flags that the legacy access changes. The native write still sets the other status bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nat_valid | input | 1 | Native access strobe |
| nat_write | input | 1 | Native access is a write |
| nat_addr | input | 12 | Native byte offset |
| nat_wdata | input | 32 | Native write data |
| nat_rdata | output | 32 | Native read data for nat_addr |
| io_valid | input | 1 | Legacy I/O access strobe |
| io_write | input | 1 | Legacy access is a write |
| io_addr | input | 16 | Legacy I/O port address |
| io_wdata | input | 8 | Legacy write data |
| io_rdata | output | 8 | Legacy read data for io_addr |
| io_hit | output | 1 | Legacy access decoded by this block |
| notify | output | 1 | One-cycle firmware notification pulse |

## Verification
The bench aims at the cycles where a native write and a legacy port access collide.

- If native writes win, the flags would show the firmware's value instead of the port side effect, or the input buffer would hold the native byte.
- Accesses made with emulation off would wrongly load the input buffer or answer on 060h and 064h.
- A read of 064h must leave status untouched, and a write to 064h must not raise notify.
- Misaligned and out-of-window native offsets are checked. A decoder that matches on partial address bits would alias them onto real registers and corrupt them.

// File: rtl/kbd_emu_pkg.sv
package kbd_emu_pkg;
    localparam int CTL_W     = 32;
    localparam int BYTE_W    = 8;
    localparam int NREG      = 4;
    localparam int EN_BIT    = 0;
    localparam int OF_BIT    = 0;
    localparam int IF_BIT    = 1;
    localparam int CD_BIT    = 3;
    localparam logic [CTL_W-1:0] CTL_RESET = 32'h0000_0010;

    typedef enum logic [1:0] {
        REG_CTL = 2'd0,
        REG_IN  = 2'd1,
        REG_OUT = 2'd2,
        REG_STS = 2'd3
    } reg_idx_e;

    typedef struct packed {
        logic [CTL_W-1:0]  ctl;
        logic [BYTE_W-1:0] inb;
        logic [BYTE_W-1:0] outb;
        logic [BYTE_W-1:0] sts;
        logic [BYTE_W-1:0] porta;
        logic              notify;
    } kbd_state_t;
endpackage

// File: rtl/kbd_nat_decode.sv
module kbd_nat_decode #(
    parameter int AW = 12,
    parameter int NREG = 4,
    parameter int STRIDE = 4,
    parameter logic [AW-1:0] BASE = 12'h100
) (
    input  logic [AW-1:0]   addr,
    output logic [NREG-1:0] sel
);
    for (genvar i = 0; i < NREG; i++) begin : g_sel
        localparam logic [AW-1:0] OFS = BASE + AW'(i * STRIDE);
        assign sel[i] = (addr == OFS);
    end
endmodule

// File: rtl/kbd_io_decode.sv
module kbd_io_decode #(
    parameter int AW = 16,
    parameter logic [AW-1:0] P_DATA = 16'h0060,
    parameter logic [AW-1:0] P_CMD  = 16'h0064,
    parameter logic [AW-1:0] P_A    = 16'h0092
) (
    input  logic [AW-1:0] io_addr,
    input  logic          emu_en,
    output logic          hit_data,
    output logic          hit_cmd,
    output logic          hit_a
);
    assign hit_data = emu_en && (io_addr == P_DATA);
    assign hit_cmd  = emu_en && (io_addr == P_CMD);
    assign hit_a    = (io_addr == P_A);
endmodule

// File: rtl/kbd_emu_regs.sv
module kbd_emu_regs
    import kbd_emu_pkg::*;
#(
    parameter int NAT_AW = 12,
    parameter int IO_AW  = 16,
    parameter logic [NAT_AW-1:0] NAT_BASE = 12'h100,
    parameter logic [IO_AW-1:0]  P_DATA = 16'h0060,
    parameter logic [IO_AW-1:0]  P_CMD  = 16'h0064,
    parameter logic [IO_AW-1:0]  P_A    = 16'h0092
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nat_valid,
    input  logic              nat_write,
    input  logic [NAT_AW-1:0] nat_addr,
    input  logic [CTL_W-1:0]  nat_wdata,
    output logic [CTL_W-1:0]  nat_rdata,
    input  logic              io_valid,
    input  logic              io_write,
    input  logic [IO_AW-1:0]  io_addr,
    input  logic [BYTE_W-1:0] io_wdata,
    output logic [BYTE_W-1:0] io_rdata,
    output logic              io_hit,
    output logic              notify
);
    localparam int STRIDE = CTL_W / 8;
    localparam logic [NAT_AW-1:0] NAT_LAST = NAT_BASE + NAT_AW'((NREG - 1) * STRIDE);

    kbd_state_t q, d;
    logic [NREG-1:0] nsel;
    logic hit_data, hit_cmd, hit_a;
    logic nat_wr, io_rd, io_wr;

    kbd_nat_decode #(.AW(NAT_AW), .NREG(NREG), .STRIDE(STRIDE), .BASE(NAT_BASE)) u_nat_dec (
        .addr(nat_addr), .sel(nsel)
    );

    kbd_io_decode #(.AW(IO_AW), .P_DATA(P_DATA), .P_CMD(P_CMD), .P_A(P_A)) u_io_dec (
        .io_addr(io_addr), .emu_en(q.ctl[EN_BIT]),
        .hit_data(hit_data), .hit_cmd(hit_cmd), .hit_a(hit_a)
    );

    assign nat_wr = nat_valid && nat_write;
    assign io_rd  = io_valid && !io_write;
    assign io_wr  = io_valid && io_write;

    // Next-state process: native writes first, legacy side effects override.
    always_comb begin
        d = q;
        if (nat_wr && nsel[REG_CTL]) d.ctl  = nat_wdata;
        if (nat_wr && nsel[REG_IN])  d.inb  = nat_wdata[BYTE_W-1:0];
        if (nat_wr && nsel[REG_OUT]) d.outb = nat_wdata[BYTE_W-1:0];
        if (nat_wr && nsel[REG_STS]) d.sts  = nat_wdata[BYTE_W-1:0];
        if (io_wr && hit_a) d.porta = io_wdata;
        if (io_wr && hit_data) begin
            d.inb         = io_wdata;
            d.sts[IF_BIT] = 1'b1;
            d.sts[CD_BIT] = 1'b0;
        end
        if (io_wr && hit_cmd) begin
            d.inb         = io_wdata;
            d.sts[IF_BIT] = 1'b0;
            d.sts[CD_BIT] = 1'b1;
        end
        if (io_rd && hit_data) d.sts[OF_BIT] = 1'b0;
        d.notify = (d.sts[IF_BIT] && !q.sts[IF_BIT]) || (q.sts[OF_BIT] && !d.sts[OF_BIT]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.ctl   <= CTL_RESET;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        nat_rdata = '0;
        unique case (1'b1)
            nsel[REG_CTL]: nat_rdata = q.ctl;
            nsel[REG_IN]:  nat_rdata = {{(CTL_W-BYTE_W){1'b0}}, q.inb};
            nsel[REG_OUT]: nat_rdata = {{(CTL_W-BYTE_W){1'b0}}, q.outb};
            nsel[REG_STS]: nat_rdata = {{(CTL_W-BYTE_W){1'b0}}, q.sts};
            default:       nat_rdata = '0;
        endcase
    end

    always_comb begin
        if (hit_data)     io_rdata = q.outb;
        else if (hit_cmd) io_rdata = q.sts;
        else if (hit_a)   io_rdata = q.porta;
        else              io_rdata = '0;
    end

    assign io_hit = io_valid && (hit_data || hit_cmd || hit_a);
    assign notify = q.notify;

    // R3
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((nat_addr < NAT_BASE) || (nat_addr > NAT_LAST) || (nat_addr[1:0] != 2'b00)) |-> (nat_rdata == '0));
    // R4
    data_rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_valid && !io_write && io_addr == P_DATA && q.ctl[EN_BIT]) |=> !q.sts[OF_BIT]);
    // R5
    data_wr_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_valid && io_write && io_addr == P_DATA && q.ctl[EN_BIT])
        |=> (q.sts[IF_BIT] && !q.sts[CD_BIT] && q.inb == $past(io_wdata)));
    // R6
    cmd_rd_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_valid && !io_write && io_addr == P_CMD && q.ctl[EN_BIT] && !nat_valid) |=> $stable(q.sts));
    // R7
    cmd_wr_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_valid && io_write && io_addr == P_CMD && q.ctl[EN_BIT])
        |=> (!q.sts[IF_BIT] && q.sts[CD_BIT] && q.inb == $past(io_wdata)));
    // R8
    emu_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.ctl[EN_BIT] && (io_addr == P_DATA || io_addr == P_CMD)) |-> (!io_hit && io_rdata == '0));
    // R10
    notify_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        notify |-> ($rose(q.sts[IF_BIT]) || $fell(q.sts[OF_BIT])));
endmodule

// File: tb/kbd_emu_regs_test.sv
`timescale 1ns/100ps
module kbd_emu_regs_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic nat_valid = 0, nat_write = 0;
    logic [11:0] nat_addr = '0;
    logic [31:0] nat_wdata = '0;
    logic [31:0] nat_rdata;
    logic io_valid = 0, io_write = 0;
    logic [15:0] io_addr = '0;
    logic [7:0] io_wdata = '0;
    logic [7:0] io_rdata;
    logic io_hit, notify;

    int errors = 0, checks = 0, cycles = 0;
    logic [31:0] last_nat;
    logic [7:0]  last_io;
    logic        last_hit;

    // behavioural reference state
    logic [31:0] m_ctl = 32'h10;
    logic [7:0]  m_in = 0, m_out = 0, m_sts = 0, m_pa = 0;
    logic        m_ntf = 0;

    always #2.5 clk = ~clk;

    kbd_emu_regs uut (
        .clk(clk), .rst_n(rst_n),
        .nat_valid(nat_valid), .nat_write(nat_write), .nat_addr(nat_addr),
        .nat_wdata(nat_wdata), .nat_rdata(nat_rdata),
        .io_valid(io_valid), .io_write(io_write), .io_addr(io_addr),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .io_hit(io_hit), .notify(notify)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] m_nat_read(input logic [11:0] a);
        case (a)
            12'h100: return m_ctl;
            12'h104: return {24'h0, m_in};
            12'h108: return {24'h0, m_out};
            12'h10C: return {24'h0, m_sts};
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic m_decoded(input logic [15:0] a);
        return (a == 16'h92) || (m_ctl[0] && (a == 16'h60 || a == 16'h64));
    endfunction

    function automatic logic [7:0] m_io_read(input logic [15:0] a);
        if (a == 16'h92) return m_pa;
        if (m_ctl[0] && a == 16'h60) return m_out;
        if (m_ctl[0] && a == 16'h64) return m_sts;
        return 8'h0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctl = 32'h10; m_in = 0; m_out = 0; m_sts = 0; m_pa = 0; m_ntf = 0;
        end else begin
            logic [7:0] old_sts;
            logic en;
            old_sts = m_sts;
            en = m_ctl[0];
            if (nat_valid && nat_write) begin
                if (nat_addr == 12'h100) m_ctl = nat_wdata;
                if (nat_addr == 12'h104) m_in  = nat_wdata[7:0];
                if (nat_addr == 12'h108) m_out = nat_wdata[7:0];
                if (nat_addr == 12'h10C) m_sts = nat_wdata[7:0];
            end
            if (io_valid) begin
                if (io_write && io_addr == 16'h92) m_pa = io_wdata;
                if (en && io_addr == 16'h60) begin
                    if (io_write) begin m_in = io_wdata; m_sts[1] = 1; m_sts[3] = 0; end
                    else m_sts[0] = 0;
                end
                if (en && io_addr == 16'h64 && io_write) begin
                    m_in = io_wdata; m_sts[1] = 0; m_sts[3] = 1;
                end
            end
            m_ntf = (m_sts[1] && !old_sts[1]) || (old_sts[0] && !m_sts[0]);
        end
    end

    always @(negedge clk) begin
        #2;
        if (rst_n) begin
            chk("MODEL nat_rdata", nat_rdata, m_nat_read(nat_addr));
            chk("MODEL io_rdata", {24'h0, io_rdata}, {24'h0, m_io_read(io_addr)});
            chk("MODEL io_hit", {31'h0, io_hit}, {31'h0, io_valid && m_decoded(io_addr)});
            chk("MODEL notify", {31'h0, notify}, {31'h0, m_ntf});
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected<=5000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic cyc(input logic nv, input logic nw, input logic [11:0] na, input logic [31:0] nd,
                       input logic iv, input logic iw, input logic [15:0] ia, input logic [7:0] id);
        @(negedge clk);
        nat_valid = nv; nat_write = nw; nat_addr = na; nat_wdata = nd;
        io_valid = iv; io_write = iw; io_addr = ia; io_wdata = id;
        #1;
        last_nat = nat_rdata; last_io = io_rdata; last_hit = io_hit;
        @(posedge clk);
        #1;
        nat_valid = 0; nat_write = 0; io_valid = 0; io_write = 0;
    endtask

    task automatic nwr(input logic [11:0] a, input logic [31:0] v);
        cyc(1, 1, a, v, 0, 0, 16'h0, 8'h0);
    endtask
    task automatic nrd(input logic [11:0] a);
        cyc(1, 0, a, 32'h0, 0, 0, 16'h0, 8'h0);
    endtask
    task automatic iwr(input logic [15:0] a, input logic [7:0] v);
        cyc(0, 0, 12'h0, 32'h0, 1, 1, a, v);
    endtask
    task automatic ird(input logic [15:0] a);
        cyc(0, 0, 12'h0, 32'h0, 1, 0, a, 8'h0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1 reset values
        nrd(12'h100); chk("R1 ctl", last_nat, 32'h10);
        nrd(12'h104); chk("R1 in", last_nat, 0);
        nrd(12'h108); chk("R1 out", last_nat, 0);
        nrd(12'h10C); chk("R1 sts", last_nat, 0);
        ird(16'h92);  chk("R1 porta", {24'h0, last_io}, 0);
        chk("R1 notify", {31'h0, notify}, 0);
        // R8 emulation disabled
        iwr(16'h60, 8'h5A); chk("R8 hit off", {31'h0, last_hit}, 0);
        nrd(12'h104); chk("R8 in unchanged", last_nat, 0);
        nrd(12'h10C); chk("R8 sts unchanged", last_nat, 0);
        ird(16'h64); chk("R8 rdata off", {24'h0, last_io}, 0);
        // R2 native map
        nwr(12'h100, 32'h0000_0011);
        nrd(12'h100); chk("R2 ctl", last_nat, 32'h11);
        nwr(12'h108, 32'hFFFF_FFA5);
        nrd(12'h108); chk("R2 out byte", last_nat, 32'hA5);
        nwr(12'h10C, 32'h0000_0001);
        nrd(12'h10C); chk("R2 sts", last_nat, 32'h01);
        // R4 data port read
        ird(16'h60); chk("R4 rdata", {24'h0, last_io}, 32'hA5);
        chk("R10 notify on OF clear", {31'h0, notify}, 1);
        nrd(12'h10C); chk("R4 OF cleared", last_nat, 0);
        chk("R10 one cycle", {31'h0, notify}, 0);
        // R5 data port write
        iwr(16'h60, 8'h3C);
        chk("R10 notify on IF set", {31'h0, notify}, 1);
        nrd(12'h104); chk("R5 in", last_nat, 32'h3C);
        nrd(12'h10C); chk("R5 sts", last_nat, 32'h02);
        // R6 status read
        ird(16'h64); chk("R6 rdata", {24'h0, last_io}, 32'h02);
        nrd(12'h10C); chk("R6 sts stable", last_nat, 32'h02);
        // R7 command port write
        iwr(16'h64, 8'hD4);
        chk("R7 no notify", {31'h0, notify}, 0);
        nrd(12'h104); chk("R7 in", last_nat, 32'hD4);
        nrd(12'h10C); chk("R7 sts", last_nat, 32'h08);
        // R9 port A
        iwr(16'h92, 8'h9E); chk("R9 hit", {31'h0, last_hit}, 1);
        ird(16'h92); chk("R9 rdata", {24'h0, last_io}, 32'h9E);
        // R3 unmapped offsets
        nwr(12'h110, 32'hDEAD_BEEF);
        nwr(12'h0FC, 32'h1234_5678);
        nwr(12'h102, 32'hFFFF_FFFF);
        nrd(12'h110); chk("R3 rd 110", last_nat, 0);
        nrd(12'h102); chk("R3 rd 102", last_nat, 0);
        nrd(12'h100); chk("R3 ctl kept", last_nat, 32'h11);
        nrd(12'h104); chk("R3 in kept", last_nat, 32'hD4);
        nrd(12'h108); chk("R3 out kept", last_nat, 32'hA5);
        nrd(12'h10C); chk("R3 sts kept", last_nat, 32'h08);
        // R11 collisions
        cyc(1, 1, 12'h10C, 32'h0B, 1, 0, 16'h60, 8'h0);
        nrd(12'h10C); chk("R11 OF wins", last_nat, 32'h0A);
        cyc(1, 1, 12'h104, 32'h77, 1, 1, 16'h64, 8'h22);
        nrd(12'h104); chk("R11 in wins", last_nat, 32'h22);
        nrd(12'h10C); chk("R11 cmd flags", last_nat, 32'h08);
        cyc(1, 1, 12'h10C, 32'h00, 1, 1, 16'h60, 8'h55);
        chk("R11 notify", {31'h0, notify}, 1);
        nrd(12'h10C); chk("R11 IF wins", last_nat, 32'h02);
        // R8 / R9 after disabling
        nwr(12'h100, 32'h10);
        iwr(16'h92, 8'h41); chk("R9 hit while off", {31'h0, last_hit}, 1);
        ird(16'h92); chk("R9 rdata while off", {24'h0, last_io}, 32'h41);
        ird(16'h60); chk("R8 no hit", {31'h0, last_hit}, 0);
        nrd(12'h10C); chk("R8 sts kept", last_nat, 32'h02);
        // R1 reset again
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        nrd(12'h10C); chk("R1 sts after reset", last_nat, 0);
        ird(16'h92); chk("R1 porta after reset", {24'h0, last_io}, 0);
        repeat (2) @(posedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule